// File: doc/BRIEF.md
# Dual-CPU doorbell interrupt mailbox

This block lets two processors ring each other's doorbells. Each processor owns an interrupt word of up to 32 bits. Software raises bits in a word by writing a one-hot or multi-bit pattern to that processor's raise register, and lowers them by writing to its lower register. Each word drives its own interrupt line, which stays asserted for as long as any bit of the word is set. The current word is read back through a read-only status register. A fixed block of identification words sits at the top of the 4 KB window.

The register port is a plain single-cycle bus: address, read strobe, write strobe, byte enables, write data. There is no back-pressure. Every access is accepted in the cycle it is presented. Read data and the access-error pulse are registered and appear in the cycle after the access. The offsets that matter to software are: status/raise/lower for processor 0 at 0x000/0x004/0x008, the same three for processor 1 at 0x010/0x014/0x018, and twelve identification words at 0xFD0 through 0xFFC.

Top module: `doorbell_mbox`

## Requirements
- R1: A read of a status register (0x000 for processor 0, 0x010 for processor 1) returns that processor's interrupt word on bus_rdata in the cycle after the access, with bus_err low.
- R2: A write to a raise register (0x004 or 0x014) ORs the write data, restricted to the valid bits, into that processor's word.
- R3: A write to a lower register (0x008 or 0x018) clears every word bit that is set in the write data.
- R4: irq[i] is high exactly when processor i's word is non-zero, from the cycle after the write that changed the word.
- R5: A write to a status register or to an identification word changes no state and pulses bus_err in the next cycle.
- R6: A read of a raise or lower register returns zero and pulses bus_err in the next cycle.
- R7: The identification words at 0xFD0, 0xFD4, and onward to 0xFFC read, in that address order, as 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, each in bits 7:0 with the upper bits zero.
- R8: A read or write to any other offset in the window returns zero, changes no state and pulses bus_err.
- R9: An access with bus_be other than 4'b1111, or with address bits 1:0 non-zero, is ignored, reads as zero and pulses bus_err.
- R10: Only the low INTR_BITS bits of each word are stored. Bits above them always read as zero and never assert an interrupt.
- R11: A synchronous active-low reset clears both words, both interrupt lines, bus_rdata and bus_err.
- R12: With both strobes high in one cycle, the write takes effect as it would alone, the read returns what it would alone, and bus_err is the OR of the two error conditions.
- R13: In a cycle after no read strobe, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a legal access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, zero when no read was made |
| bus_err | output | 1 | One-cycle pulse for an illegal access |
| irq | output | 2 | Interrupt line per processor |

## Verification
A read and a write can share one cycle. They then target the same address, so one access can update an interrupt word and also raise an access error through its read half. The bench provokes this by drawing both strobes at random and independently over every register class. It also drives a directed case that reads a raise register while writing it. Each cycle it compares bus_rdata, bus_err and both interrupt lines against a model that applies the write rule and the read rule separately and ORs their error terms.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MBOX_CPUS   = 2;
  localparam int MBOX_AW     = 12;
  localparam int ID_WORDS    = 12;
  localparam logic [MBOX_AW-1:0] CPU_STRIDE = 12'h010;
  localparam logic [MBOX_AW-1:0] OFF_STAT   = 12'h000;
  localparam logic [MBOX_AW-1:0] OFF_RAISE  = 12'h004;
  localparam logic [MBOX_AW-1:0] OFF_LOWER  = 12'h008;
  localparam logic [MBOX_AW-1:0] ID_BASE    = 12'hFD0;
  localparam logic [MBOX_AW-1:0] ID_LAST    = ID_BASE + MBOX_AW'(4 * (ID_WORDS - 1));

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_RAISE,
    SEL_LOWER,
    SEL_ID
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e   kind;
    logic        cpu;
    logic [3:0]  id_idx;
    logic        legal;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    case (idx)
      4'd0:    id_byte = 8'h04;
      4'd4:    id_byte = 8'h56;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h0B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int AW = MBOX_AW,
  parameter int BW = 4
) (
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] be,
  output dec_t          dec
);
  always_comb begin
    dec        = '0;
    dec.kind   = SEL_NONE;
    dec.legal  = (be == {BW{1'b1}}) && (addr[1:0] == 2'b00);
    for (int c = 0; c < MBOX_CPUS; c++) begin
      if (addr == (AW'(c) * CPU_STRIDE) + OFF_STAT) begin
        dec.kind = SEL_STAT;  dec.cpu = 1'(c);
      end else if (addr == (AW'(c) * CPU_STRIDE) + OFF_RAISE) begin
        dec.kind = SEL_RAISE; dec.cpu = 1'(c);
      end else if (addr == (AW'(c) * CPU_STRIDE) + OFF_LOWER) begin
        dec.kind = SEL_LOWER; dec.cpu = 1'(c);
      end
    end
    if (addr >= ID_BASE && addr <= ID_LAST && addr[1:0] == 2'b00) begin
      dec.kind   = SEL_ID;
      dec.id_idx = 4'((addr - ID_BASE) >> 2);
    end
  end
endmodule

// File: rtl/mbox_word.sv
module mbox_word #(
  parameter int          DW   = 32,
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raise_en,
  input  logic          lower_en,
  input  logic [DW-1:0] bits,
  output logic [DW-1:0] word_q,
  output logic          irq
);
  logic [DW-1:0] raise_bits, lower_bits, word_d;

  always_comb begin
    raise_bits = raise_en ? (bits & MASK) : '0;
    lower_bits = lower_en ? bits : '0;
    // lowering is applied after raising
    word_d     = (word_q | raise_bits) & ~lower_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign irq = |word_q;
endmodule

// File: rtl/mbox_id_rom.sv
module mbox_id_rom
  import mbox_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    idx,
  output logic [DW-1:0] value
);
  always_comb value = DW'(id_byte(idx));
endmodule

// File: rtl/doorbell_mbox.sv
module doorbell_mbox
  import mbox_pkg::*;
#(
  parameter int DW        = 32,
  parameter int INTR_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MBOX_AW-1:0]   bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [MBOX_CPUS-1:0] irq
);
  localparam logic [DW-1:0] VALID_MASK =
    (INTR_BITS >= DW) ? {DW{1'b1}} : DW'((64'(1) << INTR_BITS) - 64'(1));

  dec_t          dec;
  logic [DW-1:0] word_q [MBOX_CPUS];
  logic [DW-1:0] id_val;
  logic [DW-1:0] rd_d;
  logic          err_d;

  mbox_decode #(.AW(MBOX_AW), .BW(4)) u_dec (
    .addr (bus_addr),
    .be   (bus_be),
    .dec  (dec)
  );

  mbox_id_rom #(.DW(DW)) u_id (
    .idx   (dec.id_idx),
    .value (id_val)
  );

  for (genvar c = 0; c < MBOX_CPUS; c++) begin : g_cpu
    logic hit;
    assign hit = bus_we && dec.legal && (dec.cpu == 1'(c));
    mbox_word #(.DW(DW), .MASK(VALID_MASK)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .raise_en (hit && dec.kind == SEL_RAISE),
      .lower_en (hit && dec.kind == SEL_LOWER),
      .bits     (bus_wdata),
      .word_q   (word_q[c]),
      .irq      (irq[c])
    );
  end

  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    if (!dec.legal) begin
      err_d = bus_we || bus_re;
    end else begin
      unique case (dec.kind)
        SEL_STAT: begin
          rd_d  = word_q[dec.cpu];
          err_d = bus_we;
        end
        SEL_RAISE, SEL_LOWER: err_d = bus_re;
        SEL_ID: begin
          rd_d  = id_val;
          err_d = bus_we;
        end
        default: err_d = bus_we || bus_re;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_re ? rd_d : '0;
      bus_err   <= err_d;
    end
  end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk
  import mbox_pkg::*;
#(
  parameter int DW        = 32,
  parameter int INTR_BITS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [MBOX_AW-1:0]   bus_addr,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 bus_err,
  input logic [MBOX_CPUS-1:0] irq
);
  localparam logic [31:0] CHK_MASK =
    (INTR_BITS >= 32) ? 32'hFFFF_FFFF : 32'((64'(1) << INTR_BITS) - 64'(1));

  logic full;
  assign full = (bus_be == 4'hF);

  // R11
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (irq == '0 && !bus_err && bus_rdata == '0));

  // R2
  raise_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && full && bus_addr == 12'h004 && (bus_wdata & CHK_MASK) != 0) |=> irq[0]);

  // R3
  lower_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && full && bus_addr == 12'h018 && bus_wdata == 32'hFFFF_FFFF) |=> !irq[1]);

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !bus_we) |=> $stable(irq));

  // R6
  raise_read_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && full && bus_addr == 12'h014) |=> (bus_err && bus_rdata == '0));

  // R9
  partial_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_we || bus_re) && !full) |=> (bus_err && bus_rdata == '0));

  // R13
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);
endmodule

bind doorbell_mbox mbox_chk #(.DW(DW), .INTR_BITS(INTR_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .irq       (irq)
);

// File: tb/sim_doorbell_mbox.sv
`timescale 1ns/1ps
module sim_doorbell_mbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        err0, err1;
  logic [1:0]  irq0, irq1;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  logic [31:0] m0 [2];
  logic [31:0] m1 [2];

  always #5 clk = ~clk;

  doorbell_mbox u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata0), .bus_err(err0), .irq(irq0)
  );

  doorbell_mbox #(.INTR_BITS(8)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata1), .bus_err(err1), .irq(irq1)
  );

  function automatic logic [31:0] id_exp(input int k);
    logic [7:0] tab [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                             8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, tab[k]};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model one access for one instance: returns expected read data and error,
  // and updates the model word array.
  task automatic model(input logic we, input logic re, input logic [11:0] a,
                       input logic [3:0] be, input logic [31:0] wd, input logic [31:0] mask,
                       inout logic [31:0] w0, inout logic [31:0] w1,
                       output logic [31:0] rd, output logic er, output string tag);
    logic legal = (be == 4'hF) && (a[1:0] == 2'b00);
    rd = '0; er = 1'b0; tag = "R8";
    if (!legal) begin
      er = we | re; tag = "R9";
    end else if (a == 12'h000 || a == 12'h010) begin
      rd = (a == 12'h000) ? w0 : w1; er = we; tag = we ? "R5" : "R1";
    end else if (a == 12'h004 || a == 12'h014) begin
      er = re; tag = re ? "R6" : "R2";
      if (we) begin
        if (a == 12'h004) w0 = w0 | (wd & mask); else w1 = w1 | (wd & mask);
      end
    end else if (a == 12'h008 || a == 12'h018) begin
      er = re; tag = re ? "R6" : "R3";
      if (we) begin
        if (a == 12'h008) w0 = w0 & ~wd; else w1 = w1 & ~wd;
      end
    end else if (a >= 12'hFD0) begin
      rd = id_exp((a - 12'hFD0) >> 2); er = we; tag = we ? "R5" : "R7";
    end else begin
      er = we | re;
    end
    if (!re) rd = '0;
    if (we && re) tag = "R12";
  endtask

  task automatic access(input logic we, input logic re, input logic [11:0] a,
                        input logic [3:0] be, input logic [31:0] wd);
    logic [31:0] rd0, rd1;
    logic er0, er1;
    string t0, t1;
    model(we, re, a, be, wd, 32'hFFFF_FFFF, m0[0], m0[1], rd0, er0, t0);
    model(we, re, a, be, wd, 32'h0000_00FF, m1[0], m1[1], rd1, er1, t1);
    bus_we = we; bus_re = re; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    check({t0, " rdata"}, rdata0, rd0);
    check({t0, " err"}, {31'h0, err0}, {31'h0, er0});
    check("R4 irq", {30'h0, irq0}, {30'h0, (m0[1] != 0), (m0[0] != 0)});
    check("R10 rdata", rdata1, rd1);
    check("R10 irq", {30'h0, irq1}, {30'h0, (m1[1] != 0), (m1[0] != 0)});
    if (!re) check("R13 idle rdata", rdata0, 32'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    m0[0] = '0; m0[1] = '0; m1[0] = '0; m1[1] = '0;
    check("R11 irq", {30'h0, irq0}, 32'h0);
    check("R11 rdata", rdata0, 32'h0);
    check("R11 err", {31'h0, err0}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        summary();
      end
    end
  end

  initial begin
    logic [11:0] picks [8] = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018, 12'hFD0, 12'h020};
    void'($urandom(32'd2718));
    @(negedge clk);
    do_reset();

    // directed corners
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);            // R1 reset value
    access(1'b1, 1'b0, 12'h004, 4'hF, 32'h8000_0101);    // R2
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);            // R1
    access(1'b1, 1'b0, 12'h008, 4'hF, 32'h0000_0100);    // R3
    access(1'b1, 1'b0, 12'h000, 4'hF, 32'hFFFF_FFFF);    // R5 status write ignored
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);
    access(1'b1, 1'b0, 12'h014, 4'hF, 32'h0000_0200);    // R10 bit 9 masked in u1
    access(1'b1, 1'b1, 12'h014, 4'hF, 32'h0000_0001);    // R12 write plus read error
    access(1'b1, 1'b0, 12'h014, 4'h7, 32'h0000_0010);    // R9 partial ignored
    access(1'b1, 1'b0, 12'h016, 4'hF, 32'h0000_0010);    // R9 misaligned
    access(1'b0, 1'b1, 12'h010, 4'hF, 32'h0);
    for (int k = 0; k < 12; k++) access(1'b0, 1'b1, 12'(12'hFD0 + 4 * k), 4'hF, 32'h0); // R7
    access(1'b1, 1'b0, 12'hFE0, 4'hF, 32'h1234_5678);    // R5 id write
    access(1'b1, 1'b1, 12'h100, 4'hF, 32'hFFFF_FFFF);    // R8 unmapped
    access(1'b1, 1'b0, 12'h018, 4'hF, 32'hFFFF_FFFF);    // R3 clear all
    access(1'b1, 1'b0, 12'h008, 4'hF, 32'hFFFF_FFFF);
    access(1'b0, 1'b0, 12'h000, 4'hF, 32'h0);            // R13
    access(1'b1, 1'b0, 12'h004, 4'hF, 32'h0000_0040);
    do_reset();                                          // R11 mid-run
    access(1'b0, 1'b1, 12'h000, 4'hF, 32'h0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [3:0]  be;
      logic [31:0] wd;
      int sel = $urandom % 10;
      if (sel < 8) a = picks[sel];
      else if (sel == 8) a = 12'(12'hFD0 + 4 * ($urandom % 12));
      else a = 12'($urandom);
      if (a == 12'h020) a = 12'($urandom) & 12'hFFC;
      be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
      wd = (($urandom % 2) == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      access(1'($urandom), 1'($urandom), a, be, wd);
    end
    summary();
  end
endmodule